// File: doc/BRIEF.md
# Retired-Instruction PC Continuity Monitor

This block watches a single-lane instruction-retirement trace. Each retirement carries a strobe, a program-order index, the PC the instruction executed from, and the next PC it produced. The block verifies that control flow has no gaps. For any two instructions adjacent in program order, the next PC of the earlier one must equal the PC of the later one.

Instructions may retire out of program order. For that reason the monitor pairs them by order index, not by arrival time. Each retirement is checked against both neighbours:

- its predecessor (index − 1), when that one has already been seen;
- its successor (index + 1), when that one has already been seen.

Recent retirements are kept in a small table. The table slot is chosen by the low bits of the order index, and each slot holds the full index as a tag. The first mismatch raises a sticky error flag and latches an order index that points at the broken link.

Top module: `pc_chain_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `err_flag` is 0 and `err_order` is 0, and the table holds no entries. A retirement made before a reset is never compared with one made after it.
- R2: Forward check. Instruction N−1 retired earlier and is still held. When N retires with `ret_pc` different from N−1's next PC, an error is flagged and `err_order` = N.
- R3: Backward check. Instruction N+1 retired earlier and is still held. When N retires with `ret_npc` different from N+1's PC, an error is flagged and `err_order` = N+1, the index of the later instruction of the pair.
- R4: Adjacent pairs whose PCs link correctly raise no error, whether they retire in program order or in reverse.
- R5: The table has DEPTH slots (8 by default). The slot is selected by the low log2(DEPTH) bits of the order index. A later retirement into the same slot replaces the earlier one. A comparison is made only when the neighbour's slot is valid and its stored full index equals the expected neighbour index; otherwise that side is not checked.
- R6: `err_flag` stays set until reset. `err_order` keeps the index of the first mismatch; later mismatches do not change it.
- R7: If one retirement mismatches both neighbours, the forward result wins and `err_order` = N.
- R8: A mismatch on a retirement sampled at a rising edge is visible on `err_flag`/`err_order` right after that edge.
- R9: Order arithmetic wraps modulo 2^ORD_W: index 0 follows index 2^ORD_W−1.
- R10: Cycles with `ret_valid` low neither write the table nor trigger a check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ret_valid | input | 1 | A retirement is presented this cycle |
| ret_order | input | ORD_W | Program-order index of the retiring instruction |
| ret_pc | input | PC_W | PC the instruction executed from |
| ret_npc | input | PC_W | Next PC the instruction produced |
| err_flag | output | 1 | Sticky continuity error |
| err_order | output | ORD_W | Order index reported for the first mismatch |

## Verification
The main function is exercised with four kinds of pattern:

- **Linked chains, in order and reversed.** These separate a correct pairing from one that compares the wrong neighbour or the wrong field.
- **Pairs broken on one side.** Forward-only and backward-only breaks tell the two checks apart and confirm which index each one reports.
- **Same retirement broken on both sides.** This pins down the precedence rule.
- **Cases where a check must not happen.** These are an evicted or aliased slot, a reset between partners, and strobe-low junk. They separate tag matching, valid clearing and write gating from a monitor that flags too eagerly.

A wrap from the top index to zero, linked and broken, confirms the modular arithmetic.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  // Result of one retirement's neighbour comparison
  typedef enum logic [1:0] {
    MIS_NONE = 2'd0,
    MIS_FWD  = 2'd1,
    MIS_BWD  = 2'd2
  } mis_kind_e;

endpackage

// File: rtl/pcm_ret_table.sv
module pcm_ret_table #(
  parameter int DEPTH = 8,
  parameter int ORD_W = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ORD_W-1:0] wr_order,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_npc,
  input  logic [IDX_W-1:0] lo_idx,
  output logic             lo_vld,
  output logic [ORD_W-1:0] lo_tag,
  output logic [PC_W-1:0]  lo_npc,
  input  logic [IDX_W-1:0] hi_idx,
  output logic             hi_vld,
  output logic [ORD_W-1:0] hi_tag,
  output logic [PC_W-1:0]  hi_pc
);

  logic [IDX_W-1:0]            wr_idx;
  logic [DEPTH-1:0]            vld_vec;
  logic [DEPTH-1:0][ORD_W-1:0] tag_arr;
  logic [DEPTH-1:0][PC_W-1:0]  pc_arr;
  logic [DEPTH-1:0][PC_W-1:0]  npc_arr;

  assign wr_idx = wr_order[IDX_W-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             sel;
    logic             v_q;
    logic             v_d;
    logic [ORD_W-1:0] t_q;
    logic [PC_W-1:0]  p_q;
    logic [PC_W-1:0]  n_q;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      v_d = v_q | sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // Payload needs no reset: it is qualified by v_q
    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_order;
        p_q <= wr_pc;
        n_q <= wr_npc;
      end
    end

    assign vld_vec[i] = v_q;
    assign tag_arr[i] = t_q;
    assign pc_arr[i]  = p_q;
    assign npc_arr[i] = n_q;
  end

  assign lo_vld = vld_vec[lo_idx];
  assign lo_tag = tag_arr[lo_idx];
  assign lo_npc = npc_arr[lo_idx];
  assign hi_vld = vld_vec[hi_idx];
  assign hi_tag = tag_arr[hi_idx];
  assign hi_pc  = pc_arr[hi_idx];

endmodule

// File: rtl/pcm_pair_compare.sv
module pcm_pair_compare
  import pcm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ORD_W = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             ret_valid,
  input  logic [ORD_W-1:0] ret_order,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [PC_W-1:0]  ret_npc,
  output logic [IDX_W-1:0] lo_idx,
  input  logic             lo_vld,
  input  logic [ORD_W-1:0] lo_tag,
  input  logic [PC_W-1:0]  lo_npc,
  output logic [IDX_W-1:0] hi_idx,
  input  logic             hi_vld,
  input  logic [ORD_W-1:0] hi_tag,
  input  logic [PC_W-1:0]  hi_pc,
  output logic             mis_valid,
  output logic [ORD_W-1:0] mis_order
);

  logic [ORD_W-1:0] ord_m1;
  logic [ORD_W-1:0] ord_p1;
  logic             lo_match;
  logic             hi_match;
  logic             fwd_bad;
  logic             bwd_bad;
  mis_kind_e        kind;

  assign ord_m1 = ret_order - ORD_W'(1);
  assign ord_p1 = ret_order + ORD_W'(1);
  assign lo_idx = ord_m1[IDX_W-1:0];
  assign hi_idx = ord_p1[IDX_W-1:0];

  // A neighbour only counts when its slot holds exactly that index
  assign lo_match = lo_vld && (lo_tag == ord_m1);
  assign hi_match = hi_vld && (hi_tag == ord_p1);

  assign fwd_bad = ret_valid && lo_match && (lo_npc != ret_pc);
  assign bwd_bad = ret_valid && hi_match && (hi_pc != ret_npc);

  always_comb begin
    if (fwd_bad)      kind = MIS_FWD;
    else if (bwd_bad) kind = MIS_BWD;
    else              kind = MIS_NONE;
  end

  assign mis_valid = (kind != MIS_NONE);
  assign mis_order = (kind == MIS_FWD) ? ret_order : ord_p1;

endmodule

// File: rtl/pcm_err_latch.sv
module pcm_err_latch #(
  parameter int ORD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mis_valid,
  input  logic [ORD_W-1:0] mis_order,
  output logic             err_flag,
  output logic [ORD_W-1:0] err_order
);

  logic             err_q;
  logic             err_d;
  logic [ORD_W-1:0] ord_q;
  logic [ORD_W-1:0] ord_d;
  logic             ld;

  assign ld = mis_valid && !err_q;

  always_comb begin
    err_d = err_q | mis_valid;
    ord_d = ld ? mis_order : ord_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ord_q <= '0;
    end else begin
      err_q <= err_d;
      ord_q <= ord_d;
    end
  end

  assign err_flag  = err_q;
  assign err_order = ord_q;

endmodule

// File: rtl/pc_chain_monitor.sv
module pc_chain_monitor #(
  parameter int DEPTH = 8,
  parameter int ORD_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [ORD_W-1:0] ret_order,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [PC_W-1:0]  ret_npc,
  output logic             err_flag,
  output logic [ORD_W-1:0] err_order
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;
  logic             lo_vld;
  logic             hi_vld;
  logic [ORD_W-1:0] lo_tag;
  logic [ORD_W-1:0] hi_tag;
  logic [PC_W-1:0]  lo_npc;
  logic [PC_W-1:0]  hi_pc;
  logic             mis_valid;
  logic [ORD_W-1:0] mis_order;

  pcm_ret_table #(.DEPTH(DEPTH), .ORD_W(ORD_W), .PC_W(PC_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ret_valid),
    .wr_order (ret_order),
    .wr_pc    (ret_pc),
    .wr_npc   (ret_npc),
    .lo_idx   (lo_idx),
    .lo_vld   (lo_vld),
    .lo_tag   (lo_tag),
    .lo_npc   (lo_npc),
    .hi_idx   (hi_idx),
    .hi_vld   (hi_vld),
    .hi_tag   (hi_tag),
    .hi_pc    (hi_pc)
  );

  // Compares against the table contents held before this edge's write
  pcm_pair_compare #(.DEPTH(DEPTH), .ORD_W(ORD_W), .PC_W(PC_W)) u_cmp (
    .ret_valid (ret_valid),
    .ret_order (ret_order),
    .ret_pc    (ret_pc),
    .ret_npc   (ret_npc),
    .lo_idx    (lo_idx),
    .lo_vld    (lo_vld),
    .lo_tag    (lo_tag),
    .lo_npc    (lo_npc),
    .hi_idx    (hi_idx),
    .hi_vld    (hi_vld),
    .hi_tag    (hi_tag),
    .hi_pc     (hi_pc),
    .mis_valid (mis_valid),
    .mis_order (mis_order)
  );

  pcm_err_latch #(.ORD_W(ORD_W)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .mis_valid (mis_valid),
    .mis_order (mis_order),
    .err_flag  (err_flag),
    .err_order (err_order)
  );

endmodule

// File: rtl/pc_chain_monitor_chk.sv
module pc_chain_monitor_chk #(
  parameter int ORD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic [ORD_W-1:0] ret_order,
  input logic             err_flag,
  input logic [ORD_W-1:0] err_order
);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r6_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(err_order));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !err_flag) |=> !err_flag);

  a_r8_rise_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(ret_valid));

  a_r2_reported_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ((err_order == $past(ret_order)) ||
                         (err_order == $past(ret_order) + ORD_W'(1))));

  a_r1_index_zero_when_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> (err_order == '0));

endmodule

bind pc_chain_monitor pc_chain_monitor_chk #(.ORD_W(ORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ret_valid (ret_valid),
  .ret_order (ret_order),
  .err_flag  (err_flag),
  .err_order (err_order)
);

// File: tb/pc_chain_monitor_tb.sv
module pc_chain_monitor_tb;

  localparam int DEPTH = 8;
  localparam int ORD_W = 16;
  localparam int PC_W  = 32;

  logic             clk;
  logic             rst_n;
  logic             ret_valid;
  logic [ORD_W-1:0] ret_order;
  logic [PC_W-1:0]  ret_pc;
  logic [PC_W-1:0]  ret_npc;
  logic             err_flag;
  logic [ORD_W-1:0] err_order;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [ORD_W-1:0] h_ord[$];
  logic [PC_W-1:0]  h_pc[$];
  logic [PC_W-1:0]  h_npc[$];
  logic             m_flag;
  logic [ORD_W-1:0] m_order;

  pc_chain_monitor #(.DEPTH(DEPTH), .ORD_W(ORD_W), .PC_W(PC_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_order (ret_order),
    .ret_pc    (ret_pc),
    .ret_npc   (ret_npc),
    .err_flag  (err_flag),
    .err_order (err_order)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Most recent retirement landing in the same slot decides reachability
  function automatic bit lookup(input logic [ORD_W-1:0] want,
                                output logic [PC_W-1:0] pc,
                                output logic [PC_W-1:0] npc);
    pc = '0;
    npc = '0;
    for (int k = h_ord.size() - 1; k >= 0; k--) begin
      if ((int'(h_ord[k]) % DEPTH) == (int'(want) % DEPTH)) begin
        pc  = h_pc[k];
        npc = h_npc[k];
        return h_ord[k] == want;
      end
    end
    return 1'b0;
  endfunction

  task automatic model_retire(input logic [ORD_W-1:0] o,
                              input logic [PC_W-1:0] pc,
                              input logic [PC_W-1:0] npc);
    logic [PC_W-1:0] npc_pc, npc_npc, nx_pc, nx_npc;
    bit have_prev, have_next;
    have_prev = lookup(o - ORD_W'(1), npc_pc, npc_npc);
    have_next = lookup(o + ORD_W'(1), nx_pc, nx_npc);
    if (!m_flag) begin
      if (have_prev && npc_npc != pc) begin
        m_flag = 1'b1; m_order = o;
      end else if (have_next && nx_pc != npc) begin
        m_flag = 1'b1; m_order = o + ORD_W'(1);
      end
    end
    h_ord.push_back(o);
    h_pc.push_back(pc);
    h_npc.push_back(npc);
  endtask

  task automatic compare(input string req);
    checks++;
    if (err_flag !== m_flag || err_order !== m_order) begin
      fails++;
      $display("FAIL %s: err_flag=%0b err_order=%0d expected %0b/%0d",
               req, err_flag, err_order, m_flag, m_order);
    end
  endtask

  task automatic step(input bit v, input int o, input int pc, input int npc,
                      input string req);
    ret_valid = v;
    ret_order = ORD_W'(o);
    ret_pc    = PC_W'(pc);
    ret_npc   = PC_W'(npc);
    @(posedge clk);
    if (v) model_retire(ORD_W'(o), PC_W'(pc), PC_W'(npc));
    @(negedge clk);
    ret_valid = 1'b0;
    compare(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ret_valid = 1'b0;
    h_ord.delete(); h_pc.delete(); h_npc.delete();
    m_flag = 1'b0; m_order = '0;
    @(negedge clk);
    compare("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 after release");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; ret_order = '0; ret_pc = '0; ret_npc = '0;
    m_flag = 1'b0; m_order = '0;
    @(negedge clk);
    do_reset();

    // R4: linked chain in program order
    for (int i = 0; i < 6; i++) step(1, i, 'h100 + 4*i, 'h104 + 4*i, "R4 in-order chain");
    // R4: linked pair retired in reverse
    step(1, 11, 'h204, 'h208, "R4 reverse pair late");
    step(1, 10, 'h200, 'h204, "R4 reverse pair early");
    // R10: strobe-low junk must not be written
    step(0, 21, 'h999, 'h999, "R10 idle junk");
    step(1, 20, 'h4fc, 'h500, "R10 no compare with junk");
    step(0, 0, 0, 0, "R10 idle cycle");
    // R5: slot 6 evicted by alias, 31 then has no partner
    step(1, 30, 'h600, 'h604, "R5 fill slot");
    step(1, 38, 'h700, 'h704, "R5 alias overwrite");
    step(1, 31, 'h123, 'h127, "R5 evicted neighbour unchecked");
    // R1: reset separates partners
    step(1, 50, 'h800, 'h804, "R1 pre-reset retire");
    do_reset();
    step(1, 51, 'h123, 'h127, "R1 no compare across reset");
    // R9: linked wrap
    step(1, 65535, 'h900, 'h904, "R9 top index");
    step(1, 0, 'h904, 'h908, "R9 wrap linked");

    // R2 and R8: forward break, visible right after the edge
    do_reset();
    step(1, 100, 'h900, 'h904, "R2 first");
    step(1, 101, 'h950, 'h954, "R2 R8 forward mismatch");
    // R6: sticky, later mismatch ignored
    step(1, 102, 'hdead, 'hbeef, "R6 second mismatch");
    step(0, 0, 0, 0, "R6 idle held");
    step(0, 0, 0, 0, "R6 idle held again");

    // R3: backward break
    do_reset();
    step(1, 201, 'ha00, 'ha04, "R3 later first");
    step(1, 200, 'h9fc, 'ha40, "R3 backward mismatch");

    // R7: both sides broken on one retirement
    do_reset();
    step(1, 300, 'hafc, 'hb00, "R7 lower");
    step(1, 302, 'hc00, 'hc04, "R7 upper");
    step(1, 301, 'hb04, 'hc08, "R7 forward wins");

    // R9: broken wrap
    do_reset();
    step(1, 65535, 'h0c, 'h10, "R9 top index");
    step(1, 0, 'h14, 'h18, "R9 wrap mismatch");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule